// File: doc/BRIEF.md
# EEPROM Write Strobe Qualifier

This block sits between the asynchronous control pins of a byte-wide non-volatile memory and the page-write engine behind it. It samples chip-select, write-enable and output-enable through two-flop synchronizers. It filters short glitches off the two enable lines. It then turns each clean period in which both enables are low into exactly one single-cycle write event, which carries an address and a data byte.

The address is taken when the enable pair becomes jointly active, which is the falling edge of whichever enable goes low last. The data is taken when that joint period ends, which is the rising edge of whichever enable goes high first. A write does not start, or is cancelled, while output-enable is low. It is also blocked while the supply-good input is low and for a programmable lockout period after supply-good rises. The address and data buses are sampled directly. They must be held steady for at least `FILT_CYC + 4` clock cycles after the enable edge that latches them.

Top module: `ee_wr_qualifier`

## Requirements
- R1: After reset, `wr_valid` is 0 and `wr_addr` and `wr_data` are all zeros.
- R2: A write is issued when `oe_n` is high, the supply is ready, and both `cs_n` and `we_n` are low (after synchronizing and filtering). `wr_valid` pulses once, a few cycles after the first of the two enables returns high.
- R3: `wr_addr` carries the value of `addr_in` sampled when the later of the two enables has fallen. Address changes made while only one enable is low, or made after both have been low for a while, are not captured.
- R4: `wr_data` carries the value of `data_in` sampled when the first of the two enables has risen. Data changes made during the joint low period, or made after that rising edge, are not captured.
- R5: A low pulse on `cs_n` or `we_n` that is shorter than `FILT_CYC` clock cycles produces no write.
- R6: No write is issued if `oe_n` is low when the joint low period starts. A write is also cancelled if `oe_n` goes low at any point during that period.
- R7: No write is issued while `pwr_ok` is low. A write in progress is cancelled if `pwr_ok` drops during the joint low period.
- R8: After `pwr_ok` rises, writes stay blocked for `LOCK_CYC` clock cycles of synchronized supply-good.
- R9: Each joint low period yields at most one `wr_valid` pulse, and that pulse is exactly one cycle wide, however long the period lasts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| we_n | input | 1 | Write enable, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous; low inhibits writes |
| pwr_ok | input | 1 | Supply-good indication, asynchronous |
| addr_in | input | AW | Address bus |
| data_in | input | DW | Data bus |
| wr_valid | output | 1 | One-cycle qualified write event |
| wr_addr | output | AW | Latched write address |
| wr_data | output | DW | Latched write data |

## Verification
The bench changes the address bus between the first and the second enable fall, and changes the data bus during the joint low period and again after the first rise. A design that latched on the wrong edge would report the decoy value. Enable pulses shorter than the filter width, output-enable dropping in mid-period, and supply-good dropping in mid-period must all leave the scoreboard queue empty. A design that let them through would produce an unexpected pulse. A long joint low period is also held, to catch a design that repeats the event. Another write is attempted inside the power-up lockout window, to catch a design that starts counting the lockout from the wrong point.

// File: rtl/ee_wr_qualifier.sv
module ee_wr_qualifier #(
  parameter int AW       = 17,
  parameter int DW       = 8,
  parameter int FILT_CYC = 4,
  parameter int LOCK_CYC = 250000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic          pwr_ok,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] data_in,
  output logic          wr_valid,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);
  localparam int FW = $clog2(FILT_CYC + 1);
  localparam int LW = $clog2(LOCK_CYC + 1);

  logic [2:0] ctl_raw, ctl_s1, ctl_s2;
  logic       pwr_s1, pwr_s2;
  logic [1:0] en_filt;
  logic [LW-1:0] lock_cnt;
  logic en, en_q, start, stop, ready, oe_hi, armed;

  assign ctl_raw = {oe_n, we_n, cs_n};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctl_s1 <= '1;
      ctl_s2 <= '1;
      pwr_s1 <= 1'b0;
      pwr_s2 <= 1'b0;
    end else begin
      ctl_s1 <= ctl_raw;
      ctl_s2 <= ctl_s1;
      pwr_s1 <= pwr_ok;
      pwr_s2 <= pwr_s1;
    end

  for (genvar g = 0; g < 2; g++) begin : g_filt
    logic          lvl;
    logic [FW-1:0] cnt;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        lvl <= 1'b1;
        cnt <= '0;
      end else if (ctl_s2[g] == lvl) begin
        cnt <= '0;
      end else if (cnt == FW'(FILT_CYC - 1)) begin
        lvl <= ctl_s2[g];
        cnt <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    assign en_filt[g] = lvl;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                            lock_cnt <= '0;
    else if (!pwr_s2)                      lock_cnt <= '0;
    else if (lock_cnt != LW'(LOCK_CYC))    lock_cnt <= lock_cnt + 1'b1;

  assign ready = pwr_s2 && (lock_cnt == LW'(LOCK_CYC));
  assign oe_hi = ctl_s2[2];
  assign en    = ~en_filt[0] & ~en_filt[1];
  assign start = en & ~en_q;
  assign stop  = ~en & en_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en_q     <= 1'b0;
      armed    <= 1'b0;
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      en_q     <= en;
      wr_valid <= stop & armed & ready & oe_hi;
      if (start) armed <= ready & oe_hi;
      else if (stop || !ready || !oe_hi) armed <= 1'b0;
      if (start && ready && oe_hi) wr_addr <= addr_in;
      if (stop && armed && ready && oe_hi) wr_data <= data_in;
    end
endmodule

module ee_wr_qualifier_chk #(
  parameter int AW = 17
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_valid,
  input logic [AW-1:0] wr_addr,
  input logic          en_q,
  input logic          ready,
  input logic          oe_hi
);
  a_r9_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);
  a_r2_after_release: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (!en_q && $past(en_q)));
  a_r8_locked_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> !wr_valid);
  a_r6_oe_low_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_hi |=> !wr_valid);
  a_r3_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> $stable(wr_addr));
endmodule

bind ee_wr_qualifier ee_wr_qualifier_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
  .en_q(en_q), .ready(ready), .oe_hi(oe_hi)
);

// File: tb/tb_ee_wr_qualifier.sv
module tb_ee_wr_qualifier;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 17;
  localparam int DW = 8;
  localparam int FILT = 4;
  localparam int LOCK = 200;

  logic clk = 0, rst_n = 0;
  logic cs_n = 1, we_n = 1, oe_n = 1, pwr_ok = 0;
  logic [AW-1:0] addr_in = '0;
  logic [DW-1:0] data_in = '0;
  logic wr_valid;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;

  int checks = 0, errors = 0, pulses = 0;
  bit done = 0;
  logic [AW+DW-1:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ee_wr_qualifier #(.AW(AW), .DW(DW), .FILT_CYC(FILT), .LOCK_CYC(LOCK)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n),
    .pwr_ok(pwr_ok), .addr_in(addr_in), .data_in(data_in),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data));

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && wr_valid) begin
      pulses++;
      if (exp_q.size() == 0) chk(0, "R2 unexpected write", {wr_addr, wr_data}, 0);
      else begin
        logic [AW+DW-1:0] e;
        e = exp_q.pop_front();
        chk(wr_addr == e[AW+DW-1:DW], "R3 address", wr_addr, e[AW+DW-1:DW]);
        chk(wr_data == e[DW-1:0], "R4 data", wr_data, e[DW-1:0]);
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // we_first: we_n falls first and rises first; otherwise cs_n does
  task automatic wr(input bit we_first, input logic [AW-1:0] a, input logic [DW-1:0] d, input bit exp);
    if (exp) exp_q.push_back({a, d});
    addr_in = ~a; data_in = ~d;
    if (we_first) we_n = 0; else cs_n = 0;
    cyc(20);
    addr_in = a;
    if (we_first) cs_n = 0; else we_n = 0;
    cyc(20);
    addr_in = a ^ 17'h1;
    cyc(10);
    data_in = d;
    cyc(2);
    if (we_first) we_n = 1; else cs_n = 1;
    cyc(15);
    data_in = d ^ 8'h80;
    cyc(20);
    cs_n = 1; we_n = 1;
    cyc(20);
  endtask

  task automatic drained(input string tag, input int exp_pulses);
    chk(exp_q.size() == 0, tag, exp_q.size(), 0);
    chk(pulses == exp_pulses, tag, pulses, exp_pulses);
  endtask

  initial begin
    cyc(3);
    rst_n = 1;
    cyc(1);
    chk(wr_valid == 0, "R1 wr_valid", wr_valid, 0);
    chk(wr_addr == 0, "R1 wr_addr", wr_addr, 0);
    chk(wr_data == 0, "R1 wr_data", wr_data, 0);

    wr(1, 17'h05555, 8'hAA, 0);
    drained("R7 supply low", 0);

    pwr_ok = 1;
    cyc(5);
    wr(0, 17'h00123, 8'h11, 0);
    drained("R8 lockout", 0);
    cyc(LOCK);

    wr(1, 17'h1ABCD, 8'h5A, 1);
    wr(0, 17'h02AAA, 8'h55, 1);
    wr(1, 17'h00000, 8'h00, 1);
    wr(0, 17'h1FFFF, 8'hFF, 1);
    drained("R2 R3 R4 writes", 4);

    cs_n = 0; cyc(10); we_n = 0; cyc(FILT - 2); we_n = 1; cyc(30); cs_n = 1; cyc(20);
    we_n = 0; cyc(10); cs_n = 0; cyc(FILT - 1); cs_n = 1; cyc(30); we_n = 1; cyc(20);
    drained("R5 glitch", 4);

    oe_n = 0; cyc(5);
    wr(1, 17'h00777, 8'h77, 0);
    oe_n = 1; cyc(5);
    drained("R6 oe low at start", 4);

    cs_n = 0; we_n = 0; cyc(20); oe_n = 0; cyc(10); oe_n = 1; cyc(10);
    cs_n = 1; we_n = 1; cyc(30);
    drained("R6 oe low mid period", 4);

    cs_n = 0; we_n = 0; cyc(20); pwr_ok = 0; cyc(10); pwr_ok = 1; cyc(10);
    cs_n = 1; we_n = 1; cyc(30);
    drained("R7 supply drop mid period", 4);
    cyc(LOCK + 10);

    exp_q.push_back({17'h00042, 8'h3C});
    addr_in = 17'h00042; data_in = 8'h3C;
    cs_n = 0; we_n = 0; cyc(300);
    cs_n = 1; we_n = 1; cyc(30);
    drained("R9 one pulse per period", 5);

    wr(1, 17'h10001, 8'hC3, 1);
    drained("R2 write after recovery", 6);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule